// File: doc/BRIEF.md
# Parallel-to-Serial Word Serializer

This block turns a stream of parallel words into a continuous serial bit stream, lowest bit first. Words follow each other with no gap. A mode input chooses the rate. In single-rate mode one bit leaves per clock on a single output. In double-rate mode two bits leave per clock as an even/odd pair, ready for an external double-data-rate output cell. A frame clock marks word boundaries and can strobe the source of the next parallel word.

A single control input clears the whole block at once. Its release only takes effect at the next falling clock edge, so the first serial bit is never shortened. A suspend input is also sampled on falling edges. It freezes every counter and output at a word-safe point and later lets the stream continue from exactly where it stopped. The mode input may only change while the clear input is asserted.

Top module: `pser_serializer`

## Requirements
- R1: In single-rate mode each captured word leaves on `ser_out` one bit per clock, bit 0 first and bit 7 last, and the next word's bit 0 follows bit 7 of the previous word in the very next clock.
- R2: In double-rate mode each word leaves on `ser_pair` in four clocks. `ser_pair[0]` carries the even bit and `ser_pair[1]` the odd bit of each pair, so the pairs come out as (0,1), (2,3), (4,5), (6,7).
- R3: While `sync_rst` is high, `ser_out`, `ser_pair` and `frame_clk` are low. Asserting `sync_rst` clears them at once, without waiting for a clock edge.
- R4: After `sync_rst` falls, nothing moves until a falling clock edge has passed. The first word is then captured on the next rising edge in single-rate mode, and on the second rising edge in double-rate mode.
- R5: In single-rate mode, bit 0 of a word captured on rising edge E appears on `ser_out` at the falling edge that follows the sixth rising edge after E, i.e. in the seventh clock counted from E.
- R6: In double-rate mode, the pair (0,1) of a word captured on rising edge E appears on `ser_pair` just after the thirteenth rising edge after E, i.e. in the fourteenth clock counted from E.
- R7: `hold_req` is sampled on falling edges. Once it is sampled high, the following rising edges change no counter and no output. Once it is sampled low, the stream resumes with the next bit in order, with no bit lost, repeated or cut short.
- R8: In single-rate mode `frame_clk` has a period of 8 clocks and is high for 4 of them. It changes only on falling edges, and it is high exactly while bits 0 to 3 of a word are on `ser_out`.
- R9: In double-rate mode `frame_clk` has a period of 4 clocks and is high for 2 of them. It changes only on rising edges, and it is high exactly while pairs (0,1) and (2,3) of a word are on `ser_pair`.
- R10: `par_data` is sampled only on the capture edge of each word. Values it takes on any other edge never reach the serial outputs.
- R11: The output of the mode not in use stays low: `ser_pair` is 0 in single-rate mode and `ser_out` is 0 in double-rate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data registers on the rising edge, control sampling and single-rate output on the falling edge |
| sync_rst | input | 1 | Clear, asynchronous assert, release effective after the next falling edge |
| rate_dbl | input | 1 | 0: one bit per clock; 1: two bits per clock |
| hold_req | input | 1 | Suspend request, sampled on falling edges |
| par_data | input | WORD_W | Parallel word, bit 0 sent first |
| ser_out | output | 1 | Single-rate serial bit |
| ser_pair | output | 2 | Double-rate bit pair, bit 0 the even (earlier) bit |
| frame_clk | output | 1 | Word-rate frame clock |

## Verification
The bench builds the block with its default word width of 8. At that width both full latency chains stay short: the 7-clock single-rate path and the 14-clock double-rate path through all four word stages. This lets the bench sweep them cycle by cycle, with a different parallel value on every clock. Each run checks every output sample against a model that counts active rising edges from the release. It covers both modes, a mid-stream clear, and suspend windows of one, two and three clocks that land at different bit positions within a word.

// File: rtl/pser_pkg.sv
package pser_pkg;

    // Serial rate selection
    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_DOUBLE = 1'b1
    } rate_e;

endpackage

// File: rtl/pser_gate.sv
// Falling-edge control flops: release of clear and suspend sampling.
module pser_gate (
    input  logic clk,
    input  logic sync_rst,
    input  logic hold_req,
    output logic run_o,
    output logic adv_o
);

    typedef struct packed {
        logic run;
        logic act;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d     = gate_q;
        gate_d.run = 1'b1;
        gate_d.act = ~hold_req;
    end

    always_ff @(negedge clk or posedge sync_rst) begin
        if (sync_rst) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign run_o = gate_q.run;
    assign adv_o = gate_q.run & gate_q.act;

endmodule

// File: rtl/pser_core.sv
// Rising-edge word path: bit counter, word stages, shift register, DDR pair.
module pser_core
    import pser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                          clk,
    input  logic                          sync_rst,
    input  rate_e                         rate,
    input  logic                          adv,
    input  logic [WORD_W-1:0]             par_data,
    output logic                          lsb_o,
    output logic [$clog2(WORD_W)-1:0]     cnt_o,
    output logic [1:0]                    pair_o,
    output logic                          frame_o
);

    localparam int CNT_W   = $clog2(WORD_W);
    localparam int HALF    = WORD_W / 2;
    localparam int DR_LAT  = 2 * (WORD_W - 1);
    localparam int NSTG    = (DR_LAT - 1) / HALF + 1;

    localparam logic [CNT_W-1:0] SR_LAST    = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] DR_LAST    = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] SR_CAP     = CNT_W'(0);
    localparam logic [CNT_W-1:0] SR_LOAD    = CNT_W'(WORD_W - 2);
    localparam logic [CNT_W-1:0] DR_CAP     = CNT_W'(1);
    localparam logic [CNT_W-1:0] DR_LOAD    = CNT_W'(DR_LAT % HALF);
    localparam logic [CNT_W-1:0] DR_LOAD_P1 = CNT_W'(((DR_LAT % HALF) + 1) % HALF);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [NSTG-1:0][WORD_W-1:0]  stg;
        logic [WORD_W-1:0]            sh;
        logic [1:0]                   pair;
        logic                         frm;
    } core_t;

    core_t core_d, core_q;
    logic [CNT_W-1:0] wrap_at;

    assign wrap_at = (rate == RATE_DOUBLE) ? DR_LAST : SR_LAST;

    always_comb begin
        core_d = core_q;
        if (adv) begin
            core_d.cnt = (core_q.cnt == wrap_at) ? '0 : core_q.cnt + 1'b1;
            if (rate == RATE_SINGLE) begin
                if (core_q.cnt == SR_CAP) begin
                    core_d.stg[0] = par_data;
                end
                if (core_q.cnt == SR_LOAD) begin
                    core_d.sh = core_q.stg[0];
                end else begin
                    core_d.sh = core_q.sh >> 1;
                end
                core_d.pair = '0;
                core_d.frm  = 1'b0;
            end else begin
                if (core_q.cnt == DR_CAP) begin
                    core_d.stg[0] = par_data;
                    for (int s = 1; s < NSTG; s++) begin
                        core_d.stg[s] = core_q.stg[s-1];
                    end
                end
                if (core_q.cnt == DR_LOAD) begin
                    core_d.pair = core_q.stg[NSTG-1][1:0];
                    core_d.sh   = core_q.stg[NSTG-1] >> 2;
                end else begin
                    core_d.pair = core_q.sh[1:0];
                    core_d.sh   = core_q.sh >> 2;
                end
                core_d.frm = (core_q.cnt == DR_LOAD) || (core_q.cnt == DR_LOAD_P1);
            end
        end
    end

    always_ff @(posedge clk or posedge sync_rst) begin
        if (sync_rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign lsb_o   = core_q.sh[0];
    assign cnt_o   = core_q.cnt;
    assign pair_o  = core_q.pair;
    assign frame_o = core_q.frm;

endmodule

// File: rtl/pser_neg_out.sv
// Falling-edge retiming of the single-rate bit and its frame clock.
module pser_neg_out
    import pser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                      clk,
    input  logic                      sync_rst,
    input  logic                      run,
    input  rate_e                     rate,
    input  logic                      lsb,
    input  logic [$clog2(WORD_W)-1:0] cnt,
    output logic                      ser_o,
    output logic                      frame_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] SR_LAST  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(WORD_W / 2 - 1);

    typedef struct packed {
        logic ser;
        logic frm;
    } nout_t;

    nout_t nout_d, nout_q;

    always_comb begin
        nout_d = nout_q;
        if (run) begin
            if (rate == RATE_SINGLE) begin
                nout_d.ser = lsb;
                // high while bits 0..HALF-1 of the word are on the line
                nout_d.frm = (cnt == SR_LAST) || (cnt < FRM_LAST);
            end else begin
                nout_d.ser = 1'b0;
                nout_d.frm = 1'b0;
            end
        end
    end

    always_ff @(negedge clk or posedge sync_rst) begin
        if (sync_rst) begin
            nout_q <= '0;
        end else begin
            nout_q <= nout_d;
        end
    end

    assign ser_o   = nout_q.ser;
    assign frame_o = nout_q.frm;

endmodule

// File: rtl/pser_serializer.sv
// Parallel-to-serial word serializer, single- or double-rate.
module pser_serializer
    import pser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              sync_rst,
    input  logic              rate_dbl,
    input  logic              hold_req,
    input  logic [WORD_W-1:0] par_data,
    output logic              ser_out,
    output logic [1:0]        ser_pair,
    output logic              frame_clk
);

    localparam int CNT_W = $clog2(WORD_W);

    rate_e            rate;
    logic             run;
    logic             adv;
    logic             core_lsb;
    logic [CNT_W-1:0] core_cnt;
    logic             frame_dr;
    logic             frame_sr;

    assign rate = rate_e'(rate_dbl);

    pser_gate u_gate (
        .clk      (clk),
        .sync_rst (sync_rst),
        .hold_req (hold_req),
        .run_o    (run),
        .adv_o    (adv)
    );

    pser_core #(.WORD_W(WORD_W)) u_core (
        .clk      (clk),
        .sync_rst (sync_rst),
        .rate     (rate),
        .adv      (adv),
        .par_data (par_data),
        .lsb_o    (core_lsb),
        .cnt_o    (core_cnt),
        .pair_o   (ser_pair),
        .frame_o  (frame_dr)
    );

    pser_neg_out #(.WORD_W(WORD_W)) u_nout (
        .clk      (clk),
        .sync_rst (sync_rst),
        .run      (run),
        .rate     (rate),
        .lsb      (core_lsb),
        .cnt      (core_cnt),
        .ser_o    (ser_out),
        .frame_o  (frame_sr)
    );

    assign frame_clk = (rate == RATE_DOUBLE) ? frame_dr : frame_sr;

endmodule

// File: rtl/pser_checker.sv
// Property checker for the serializer, attached by bind.
module pser_checker #(
    parameter int WORD_W = 8
) (
    input logic                      clk,
    input logic                      sync_rst,
    input logic                      rate_dbl,
    input logic                      adv,
    input logic [$clog2(WORD_W)-1:0] cnt,
    input logic                      ser_out,
    input logic [1:0]                ser_pair,
    input logic                      frame_clk
);

    // R3
    reset_quiet_chk: assert property (@(posedge clk)
        sync_rst |-> (!ser_out && ser_pair == 2'b00 && !frame_clk));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (sync_rst)
        !adv |=> ($stable(ser_out) && $stable(ser_pair) && $stable(frame_clk) && $stable(cnt)));

    // R11
    pair_idle_chk: assert property (@(posedge clk) disable iff (sync_rst)
        !rate_dbl |-> (ser_pair == 2'b00));

    // R11
    bit_idle_chk: assert property (@(posedge clk) disable iff (sync_rst)
        rate_dbl |-> !ser_out);

    always @(frame_clk) begin
        if (sync_rst === 1'b0) begin
            if (rate_dbl) begin
                // R9
                frame_rise_chk: assert (clk === 1'b1);
            end else begin
                // R8
                frame_fall_chk: assert (clk === 1'b0);
            end
        end
    end

endmodule

bind pser_serializer pser_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .sync_rst  (sync_rst),
    .rate_dbl  (rate_dbl),
    .adv       (adv),
    .cnt       (core_cnt),
    .ser_out   (ser_out),
    .ser_pair  (ser_pair),
    .frame_clk (frame_clk)
);

// File: tb/pser_serializer_tb.sv
`timescale 1ns/1ps
module pser_serializer_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         sync_rst = 1'b1;
    logic         rate_dbl = 1'b0;
    logic         hold_req = 1'b0;
    logic [W-1:0] par_data = '0;
    logic         ser_out;
    logic [1:0]   ser_pair;
    logic         frame_clk;

    int checks = 0;
    int fails  = 0;

    // Reference model state, built from the stated timing rules
    bit           m_run = 1'b0;
    bit           m_act = 1'b0;
    int           n = 0;
    logic [W-1:0] hist [0:1023];

    pser_serializer #(.WORD_W(W)) u_dut (
        .clk       (clk),
        .sync_rst  (sync_rst),
        .rate_dbl  (rate_dbl),
        .hold_req  (hold_req),
        .par_data  (par_data),
        .ser_out   (ser_out),
        .ser_pair  (ser_pair),
        .frame_clk (frame_clk)
    );

    always #4 clk = ~clk;

    always @(posedge sync_rst) begin
        m_run = 1'b0;
        m_act = 1'b0;
    end

    // R4, R7: release and suspend take effect at falling edges
    always @(negedge clk) begin
        if (sync_rst) begin
            m_run = 1'b0;
            m_act = 1'b0;
        end else begin
            m_run = 1'b1;
            m_act = !hold_req;
        end
    end

    // Count active rising edges and record the data present at each
    always @(posedge clk) begin
        if (sync_rst) begin
            n = 0;
        end else if (m_run && m_act) begin
            hist[n] = par_data;
            n++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_mode(input bit dbl, input int cycles);
        int since_hold;
        since_hold = 100;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            if (i == 0) sync_rst = 1'b0;
            par_data = W'((i * 37 + 11) ^ (dbl ? 8'h5a : 8'h00));
            hold_req = ((i >= 40 && i < 43) || (i >= 71 && i < 73) || i == 95);
            since_hold = hold_req ? 0 : since_hold + 1;
            #1;
            if (dbl && n >= 1) begin
                int m;
                int exp_pair;
                int exp_frm;
                string tag;
                m = n - 15;
                exp_pair = 0;
                if (m >= 0) begin
                    int w;
                    int p;
                    w = 4 * (m / 4) + 1;
                    p = m % 4;
                    exp_pair = {hist[w][2*p+1], hist[w][2*p]};
                end
                if (m < 0 || m == 0) tag = "R6";
                else if (m < 4) tag = "R4";
                else if (since_hold < 16) tag = "R7";
                else if ((m / 4) % 2 == 1) tag = "R10";
                else tag = "R2";
                check(tag, ser_pair, exp_pair);
                exp_frm = (((n - 1) % 4) >= 2) ? 1 : 0;
                check(since_hold < 16 ? "R7 R9" : "R9", frame_clk, exp_frm);
                check("R11", ser_out, 0);
            end
            #4;
            if (!dbl && n >= 1) begin
                int m;
                int exp_bit;
                int exp_frm;
                string tag;
                m = n - 7;
                exp_bit = 0;
                if (m >= 0) exp_bit = hist[8 * (m / 8)][m % 8];
                if (m <= 0) tag = "R5";
                else if (m < 8) tag = "R4";
                else if (since_hold < 16) tag = "R7";
                else if ((m / 8) % 2 == 1) tag = "R10";
                else tag = "R1";
                check(tag, ser_out, exp_bit);
                exp_frm = (((n + 1) % 8) < 4) ? 1 : 0;
                check(since_hold < 16 ? "R7 R8" : "R8", frame_clk, exp_frm);
                check("R11", ser_pair, 0);
            end
        end
        hold_req = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R3", ser_out, 0);
        check("R3", ser_pair, 0);
        check("R3", frame_clk, 0);

        rate_dbl = 1'b0;
        run_mode(1'b0, 130);

        // mid-stream clear: outputs must drop before any further edge
        @(posedge clk);
        #1;
        sync_rst = 1'b1;
        #1;
        check("R3", ser_out, 0);
        check("R3", ser_pair, 0);
        check("R3", frame_clk, 0);
        rate_dbl = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R3", frame_clk, 0);
        check("R3", ser_pair, 0);

        run_mode(1'b1, 130);

        @(posedge clk);
        #1;
        sync_rst = 1'b1;
        #1;
        check("R3", ser_pair, 0);
        check("R3", frame_clk, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule